// File: doc/BRIEF.md
# Programmable Reference Divider with Selectable Detector Phases

This block divides a reference clock by a programmable integer ratio. Each completed divide period advances a three-bit binary phase counter. The counter values 0, 2, 4 and 6 form four candidate strobes. Two independent 2-bit selectors each pick one of those strobes. One selector drives the main phase-detector strobe and the other drives the auxiliary one. Both detector outputs are registered. Each is a single reference-clock cycle wide.

The control fields arrive in parallel: the ratio, the two selectors and two enable bits. The block runs while either enable is high. When both enables are low, the block parks with its divider and phase counter cleared and both outputs low. A ratio written while the block is running takes effect only after the divide period in progress has finished.

Top module: `refdiv`

## Requirements
- R1: With an effective ratio N (4 to 4095), the divider completes one period every N reference cycles, so each selected strobe repeats every 8·N cycles.
- R2: A ratio field value of 0, 1, 2 or 3 is treated as a ratio of 4.
- R3: The three-bit phase counter advances by one (modulo 8) at each completed divide period and at no other time.
- R4: Selector value k on `sel_main` makes `main_pd_pulse` fire in the cycle that follows the edge at which the phase counter becomes 2·k. For k = 0 this is the wrap from 7 to 0.
- R5: `sel_aux` chooses the pulse for `aux_pd_pulse` by the same rule, independently of `sel_main`.
- R6: Every strobe on either output lasts exactly one reference-clock cycle.
- R7: The block runs when `en_aux` or `en_main` is 1. When both are 0, the next clock edge clears the divider and the phase counter and drives both outputs low. On re-enable, counting restarts from zero.
- R8: A ratio change during a running period takes effect only when that period completes, so no period is ever shortened.
- R9: While `rst_n` is low, both outputs are low and the counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_aux | input | 1 | Enable request from the auxiliary path |
| en_main | input | 1 | Enable request from the main path |
| div_ratio | input | 12 | Integer divide ratio (values below 4 act as 4) |
| sel_main | input | 2 | Phase pick for the main detector strobe |
| sel_aux | input | 2 | Phase pick for the auxiliary detector strobe |
| main_pd_pulse | output | 1 | Main detector strobe |
| aux_pd_pulse | output | 1 | Auxiliary detector strobe |

## Verification
The bench targets the ratio floor at 0, 1 and 3. A design without the clamp would divide by one or stall, and its strobe spacing would be wrong. The bench also writes a new ratio in the middle of a period. A design that loads it immediately would produce a shortened period and an early strobe.

Other cases are the selector value 0, the full 4095 ratio and enable dropouts. For selector 0, an off-by-one in the phase match would fire on phase 1 or 7. At ratio 4095, a truncated counter would wrap early. After an enable dropout, a design that resumes rather than restarts would strobe too soon. Each enable is also exercised alone, which exposes an AND where an OR belongs.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int RATIO_W   = 12;
  localparam int MIN_RATIO = 4;
  localparam int PHASE_W   = 3;
  localparam int SEL_W     = 2;
  localparam int N_PATHS   = 2;

  typedef enum int {PATH_MAIN = 0, PATH_AUX = 1} path_e;

  // phase value a selector code points at: k scaled to the even counter steps
  function automatic int phase_for_sel(input int k, input int pw, input int sw);
    return k << (pw - sw);
  endfunction
endpackage

// File: rtl/refdiv_intdiv.sv
module refdiv_intdiv #(
  parameter int RW   = 12,
  parameter int MINR = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [RW-1:0] ratio_in,
  output logic          tick,
  output logic [RW-1:0] ratio_q,
  output logic [RW-1:0] cnt_q
);
  localparam logic [RW-1:0] FLOOR = RW'(MINR);

  function automatic logic [RW-1:0] clamp_ratio(input logic [RW-1:0] r);
    return (r < FLOOR) ? FLOOR : r;
  endfunction

  logic [RW-1:0] last_cnt;
  assign last_cnt = ratio_q - RW'(1);
  assign tick     = active && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= FLOOR;
    end else if (!active) begin
      cnt_q   <= '0;
      ratio_q <= clamp_ratio(ratio_in);
    end else if (tick) begin
      cnt_q   <= '0;
      ratio_q <= clamp_ratio(ratio_in);
    end else begin
      cnt_q   <= cnt_q + RW'(1);
    end
  end
endmodule

// File: rtl/refdiv_phase.sv
module refdiv_phase #(
  parameter int CW = 3,
  parameter int SW = 2,
  localparam int NP = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  output logic [CW-1:0] phase_q,
  output logic [NP-1:0] strobe
);
  logic [CW-1:0] phase_next;
  assign phase_next = phase_q + CW'(1);

  for (genvar k = 0; k < NP; k++) begin : g_strobe
    localparam logic [CW-1:0] TARGET = CW'(refdiv_pkg::phase_for_sel(k, CW, SW));
    assign strobe[k] = tick && (phase_next == TARGET);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) phase_q <= '0;
    else if (tick)         phase_q <= phase_next;
  end
endmodule

// File: rtl/refdiv_select.sv
module refdiv_select #(
  parameter int SW = 2,
  localparam int NP = 1 << SW
) (
  input  logic [NP-1:0] strobe,
  input  logic [SW-1:0] sel,
  output logic          pick
);
  assign pick = strobe[sel];
endmodule

// File: rtl/refdiv.sv
module refdiv #(
  parameter int RATIO_W   = refdiv_pkg::RATIO_W,
  parameter int MIN_RATIO = refdiv_pkg::MIN_RATIO,
  parameter int PHASE_W   = refdiv_pkg::PHASE_W,
  parameter int SEL_W     = refdiv_pkg::SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_aux,
  input  logic               en_main,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic [SEL_W-1:0]   sel_main,
  input  logic [SEL_W-1:0]   sel_aux,
  output logic               main_pd_pulse,
  output logic               aux_pd_pulse
);
  import refdiv_pkg::*;
  localparam int NP = 1 << SEL_W;

  logic               active;
  logic               div_tick;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] div_cnt;
  logic [PHASE_W-1:0] phase_q;
  logic [NP-1:0]      strobes;
  logic [SEL_W-1:0]   path_sel [N_PATHS];
  logic [N_PATHS-1:0] path_pick;
  logic [N_PATHS-1:0] path_q;

  assign active = en_aux | en_main;
  assign path_sel[PATH_MAIN] = sel_main;
  assign path_sel[PATH_AUX]  = sel_aux;

  refdiv_intdiv #(.RW(RATIO_W), .MINR(MIN_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .active(active), .ratio_in(div_ratio),
    .tick(div_tick), .ratio_q(ratio_q), .cnt_q(div_cnt)
  );

  refdiv_phase #(.CW(PHASE_W), .SW(SEL_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(div_tick),
    .phase_q(phase_q), .strobe(strobes)
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    refdiv_select #(.SW(SEL_W)) u_sel (
      .strobe(strobes), .sel(path_sel[p]), .pick(path_pick[p])
    );
    always_ff @(posedge clk) begin
      if (!rst_n) path_q[p] <= 1'b0;
      else        path_q[p] <= active & path_pick[p];
    end
  end

  assign main_pd_pulse = path_q[PATH_MAIN];
  assign aux_pd_pulse  = path_q[PATH_AUX];
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int RW   = 12,
  parameter int MINR = 4,
  parameter int CW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          tick,
  input logic [RW-1:0] ratio_q,
  input logic [RW-1:0] cnt_q,
  input logic [CW-1:0] phase_q,
  input logic          main_o,
  input logic          aux_o
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!main_o && !aux_o));
  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (phase_q == '0 && cnt_q == '0));
  // R6
  main_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_o |=> !main_o);
  // R6
  aux_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_o |=> !aux_o);
  // R3
  main_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_o |-> $past(tick));
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(phase_q));
  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(ratio_q));
  // R2
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RW'(MINR));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);
endmodule

bind refdiv refdiv_chk #(.RW(RATIO_W), .MINR(MIN_RATIO), .CW(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .tick(div_tick),
  .ratio_q(ratio_q), .cnt_q(div_cnt), .phase_q(phase_q),
  .main_o(main_pd_pulse), .aux_o(aux_pd_pulse)
);

// File: tb/tb_refdiv.sv
module tb_refdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_aux = 1'b0, en_main = 1'b0;
  logic [11:0] div_ratio = 12'd4;
  logic [1:0]  sel_main = 2'd0, sel_aux = 2'd0;
  logic        main_pd_pulse, aux_pd_pulse;

  always #10 clk = ~clk;   // 50 MHz

  refdiv dut (
    .clk(clk), .rst_n(rst_n), .en_aux(en_aux), .en_main(en_main),
    .div_ratio(div_ratio), .sel_main(sel_main), .sel_aux(sel_aux),
    .main_pd_pulse(main_pd_pulse), .aux_pd_pulse(aux_pd_pulse)
  );

  typedef struct {
    logic  m;
    logic  a;
    string req;
  } exp_t;

  exp_t  sbq[$];
  int    vectors = 0;
  int    misses  = 0;
  string tag     = "R9";
  bit    done    = 0;

  // bench-side view of the divider: position in period, period length, phase
  int m_pos = 0, m_len = 4, m_ph = 0;

  function automatic int eff_ratio(input int r);
    return (r < 4) ? 4 : r;
  endfunction

  // driver: predicts the outputs after the coming edge, then lets it pass
  task automatic step();
    exp_t e;
    e.m = 1'b0; e.a = 1'b0; e.req = tag;
    if (!rst_n) begin
      m_pos = 0; m_ph = 0; m_len = 4;
    end else if (!(en_aux || en_main)) begin
      m_pos = 0; m_ph = 0; m_len = eff_ratio(int'(div_ratio));
    end else if (m_pos + 1 == m_len) begin
      m_pos = 0;
      m_ph  = (m_ph + 1) % 8;
      m_len = eff_ratio(int'(div_ratio));
      e.m = (m_ph == 2 * int'(sel_main));
      e.a = (m_ph == 2 * int'(sel_aux));
    end else begin
      m_pos++;
    end
    sbq.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // monitor: pops one prediction per edge and compares mid-cycle
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      vectors++;
      if (main_pd_pulse !== e.m || aux_pd_pulse !== e.a) begin
        misses++;
        $display("FAIL %s: main/aux actual %b%b expected %b%b at %0t",
                 e.req, main_pd_pulse, aux_pd_pulse, e.m, e.a, $time);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R9"; rst_n = 1'b0; run(3);            // reset state
    rst_n = 1'b1;
    tag = "R7"; run(2);                          // both enables low
    // R1 R3 R4 R5 R6: ratio 4, main on phase 2, aux on phase 6
    tag = "R1/R3/R4/R5/R6"; div_ratio = 12'd4; sel_main = 2'd1; sel_aux = 2'd3;
    en_main = 1'b1; run(80);
    tag = "R4/R5"; sel_main = 2'd0; sel_aux = 2'd2; run(70);   // k=0 wrap case
    tag = "R7"; en_main = 1'b0; en_aux = 1'b1; run(40);        // aux enable alone
    tag = "R7"; en_aux = 1'b0; run(50);                        // idle
    tag = "R1"; div_ratio = 12'd5; sel_main = 2'd2; sel_aux = 2'd1;
    en_main = 1'b1; en_aux = 1'b1; run(100);
    // R2: floor on small ratio values
    tag = "R2"; en_main = 1'b0; en_aux = 1'b0; div_ratio = 12'd1; run(2);
    en_main = 1'b1; run(80);
    div_ratio = 12'd0; run(40);
    div_ratio = 12'd3; run(40);
    // R8: ratio change in the middle of a period
    tag = "R8"; en_main = 1'b0; div_ratio = 12'd10; sel_main = 2'd1; sel_aux = 2'd0;
    run(2);
    en_main = 1'b1; run(23);
    div_ratio = 12'd4; run(100);
    // R7: dropout then restart from zero
    tag = "R7"; run(13);
    en_main = 1'b0; run(1);
    en_aux = 1'b1; run(60);
    // R1: largest ratio
    tag = "R1"; en_aux = 1'b0; div_ratio = 12'd4095; sel_main = 2'd1; sel_aux = 2'd0;
    run(1);
    en_main = 1'b1; run(8200);
    @(posedge clk); #8;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule